// File: doc/BRIEF.md
# Per-Instruction Stride Predictor for Data Address Traces

This block shrinks the stream of data addresses produced by loads and stores. Each memory access presents the program counter of the instruction and the address it touched. The program counter selects one entry of a direct-mapped table. That entry remembers the previous address the same instruction used and the step between its last two addresses. When the new step equals the remembered step, the access is reduced to a single flag bit. Otherwise the flag marks a miss, and the full address goes out on a separate miss channel.

Accesses enter through a small input queue that absorbs bursts. The comparison engine takes two cycles per access and does not overlap accesses, so a long run of back-to-back accesses fills the queue. The core then drops its ready signal until space frees up. The flag stream and the miss stream leave the block in the order the accesses arrived. They are meant to feed a trace port or a later compression stage.

Top module: `stride_trace_cache`

## Requirements
- R1: After reset `acc_ready_o` is 1, `flag_valid_o` and `miss_valid_o` are 0, and every table entry is invalid.
- R2: The table entry index is `acc_pc_i[IDX_W+1:2]` (bits 11:2 by default). Two program counters that agree in those bits share one entry.
- R3: An access to an invalid entry is always a miss. Afterwards the entry becomes valid and holds the address with a stored step of 0.
- R4: An access to a valid entry is a hit when (address − stored address) equals the stored step. The flag encoding is `flag_hit_o`=1 for a hit and 0 for a miss.
- R5: On a miss, `miss_valid_o` pulses in the same cycle as `flag_valid_o`, and `miss_addr_o` carries the full access address. On a hit, `miss_valid_o` stays 0.
- R6: Every access, hit or miss, rewrites its entry. The stored address becomes the new address, and the stored step becomes the new difference.
- R7: For an access accepted at rising edge k into an idle block, the result is visible after edge k+2, and not after edge k or edge k+1. `flag_valid_o` is a one-cycle pulse. At most one result appears every two cycles.
- R8: The input queue holds FIFO_DEPTH (8) accesses. `acc_ready_o` is 0 while it is full, and an access offered while `acc_ready_o` is 0 is ignored. Results leave in arrival order.
- R9: Address differences are computed modulo 2^ADDR_W, so a step across the top of the address space still matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Memory access offered |
| acc_ready_o | output | 1 | Input queue can take an access |
| acc_pc_i | input | PC_W | Program counter of the memory instruction |
| acc_addr_i | input | ADDR_W | Data address of the access |
| flag_valid_o | output | 1 | One result flag is present |
| flag_hit_o | output | 1 | 1 = step predicted, 0 = mispredicted |
| miss_valid_o | output | 1 | Full address present on miss channel |
| miss_addr_o | output | ADDR_W | Address of a mispredicted access |

## Verification
A corrupted stored address or stored step shows up as a wrong flag on the next access to the same entry. With a consistent step, a hit would turn into a miss and carry the address out, or the reverse, within two cycles of that access being popped. A stale valid bit after reset would show as a hit on the first access. Index aliasing is exposed by two program counters that share index bits, where one continues the other's step. Queue faults such as overflow, lost order or duplicates show up as a wrong count or a wrong order of flags during a saturating burst.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic {ST_IDLE, ST_CMP} stc_state_e;
endpackage

// File: rtl/stc_fifo.sv
module stc_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign data_o  = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i && !full_o) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i && !empty_o) rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i && !full_o, pop_i && !empty_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/stc_table.sv
module stc_table #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [ADDR_W-1:0] last_q [ENTRIES];
  logic [ADDR_W-1:0] step_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic [ADDR_W-1:0] diff;
  logic [ADDR_W-1:0] new_step;

  // modulo-2^ADDR_W difference
  assign diff     = addr_i - last_q[idx_i];
  assign hit_o    = vld_q[idx_i] && (diff == step_q[idx_i]);
  assign new_step = vld_q[idx_i] ? diff : '0;

  always_ff @(posedge clk_i) begin
    if (upd_i) begin
      last_q[idx_i] <= addr_i;
      step_q[idx_i] <= new_step;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (upd_i) vld_q[idx_i] <= 1'b1;
  end

  a_r6_entry_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> vld_q[$past(idx_i)]);
  a_r6_addr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> last_q[$past(idx_i)] == $past(addr_i));
endmodule

// File: rtl/stride_trace_cache.sv
module stride_trace_cache #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  output logic              acc_ready_o,
  input  logic [PC_W-1:0]   acc_pc_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              flag_valid_o,
  output logic              flag_hit_o,
  output logic              miss_valid_o,
  output logic [ADDR_W-1:0] miss_addr_o
);
  import stc_pkg::*;

  localparam int unsigned ENT_W = IDX_W + ADDR_W;

  logic [ENT_W-1:0] q_in, q_out;
  logic             q_full, q_empty, q_pop;
  logic             tbl_hit;
  stc_state_e       st_q;
  logic [IDX_W-1:0]  hold_idx_q;
  logic [ADDR_W-1:0] hold_addr_q;

  // word-aligned PC bits select the entry
  assign q_in        = {acc_pc_i[IDX_W+1:2], acc_addr_i};
  assign acc_ready_o = !q_full;
  assign q_pop       = (st_q == ST_IDLE) && !q_empty;

  stc_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (acc_valid_i),
    .data_i  (q_in),
    .pop_i   (q_pop),
    .data_o  (q_out),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  stc_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (st_q == ST_CMP),
    .idx_i  (hold_idx_q),
    .addr_i (hold_addr_q),
    .hit_o  (tbl_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      hold_idx_q   <= '0;
      hold_addr_q  <= '0;
      flag_valid_o <= 1'b0;
      flag_hit_o   <= 1'b0;
      miss_valid_o <= 1'b0;
      miss_addr_o  <= '0;
    end else begin
      flag_valid_o <= 1'b0;
      miss_valid_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (!q_empty) begin
          {hold_idx_q, hold_addr_q} <= q_out;
          st_q <= ST_CMP;
        end
        ST_CMP: begin
          flag_valid_o <= 1'b1;
          flag_hit_o   <= tbl_hit;
          miss_valid_o <= !tbl_hit;
          if (!tbl_hit) miss_addr_o <= hold_addr_q;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r5_miss_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_o |-> flag_valid_o && !flag_hit_o);
  a_r5_hit_no_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_valid_o && flag_hit_o) |-> !miss_valid_o);
  a_r7_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_valid_o |=> !flag_valid_o);
  a_r7_after_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_valid_o) |-> $past(st_q == ST_CMP));
endmodule

// File: tb/sim_stride_trace_cache.sv
module sim_stride_trace_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;
  localparam int NBURST = 24;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] addr;
    logic        hit;
  } vec_t;

  // R2: 0x100 and 0x1100 share index 0x040
  localparam vec_t VECS [NVEC] = '{
    '{32'h100,  32'h1000,     1'b0},
    '{32'h100,  32'h1008,     1'b0},
    '{32'h100,  32'h1010,     1'b1},
    '{32'h100,  32'h1018,     1'b1},
    '{32'h100,  32'h1014,     1'b0},
    '{32'h100,  32'h1010,     1'b1},
    '{32'h100,  32'h100C,     1'b1},
    '{32'h204,  32'h2000,     1'b0},
    '{32'h100,  32'h1008,     1'b1},
    '{32'h1100, 32'h1004,     1'b1},
    '{32'h100,  32'h5000,     1'b0},
    '{32'h300,  32'h7000,     1'b0},
    '{32'h300,  32'h7000,     1'b1},
    '{32'h400,  32'hFFFFFFF8, 1'b0},
    '{32'h400,  32'hFFFFFFFC, 1'b0},
    '{32'h400,  32'h00000000, 1'b1},
    '{32'h400,  32'h00000004, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_pc = '0;
  logic [31:0] acc_addr = '0;
  logic        flag_valid, flag_hit, miss_valid;
  logic [31:0] miss_addr;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  bit          rec_en = 1'b0;
  int          obs_n = 0;
  logic        obs_hit [64];
  logic        obs_miss [64];
  logic [31:0] obs_addr [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  stride_trace_cache u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .acc_valid_i  (acc_valid),
    .acc_ready_o  (acc_ready),
    .acc_pc_i     (acc_pc),
    .acc_addr_i   (acc_addr),
    .flag_valid_o (flag_valid),
    .flag_hit_o   (flag_hit),
    .miss_valid_o (miss_valid),
    .miss_addr_o  (miss_addr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rec_en && flag_valid && obs_n < 64) begin
      obs_hit[obs_n]  = flag_hit;
      obs_miss[obs_n] = miss_valid;
      obs_addr[obs_n] = miss_addr;
      obs_n++;
    end
  end

  // R7 timing: accepted at edge k, result after edge k+2
  task automatic do_access(input logic [31:0] pc, input logic [31:0] addr, input logic exp_hit);
    @(negedge clk);
    acc_valid = 1'b1; acc_pc = pc; acc_addr = addr;
    @(negedge clk);
    acc_valid = 1'b0;
    check(flag_valid == 1'b0, "R7 early after k", flag_valid, 0);
    @(negedge clk);
    check(flag_valid == 1'b0, "R7 early after k+1", flag_valid, 0);
    @(negedge clk);
    check(flag_valid == 1'b1, "R7 result after k+2", flag_valid, 1);
    check(flag_hit == exp_hit, "R4 flag", flag_hit, exp_hit);
    check(miss_valid == !exp_hit, "R5 miss valid", miss_valid, !exp_hit);
    if (!exp_hit) check(miss_addr == addr, "R5 miss addr", miss_addr, addr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit saw_full;
    repeat (3) @(negedge clk);
    check(acc_ready == 1'b1, "R1 ready", acc_ready, 1);
    check(flag_valid == 1'b0, "R1 flag", flag_valid, 0);
    check(miss_valid == 1'b0, "R1 miss", miss_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(acc_ready == 1'b1, "R1 ready after release", acc_ready, 1);

    // R2 R3 R4 R5 R6 R9 vector walk
    for (int i = 0; i < NVEC; i++)
      do_access(VECS[i].pc, VECS[i].addr, VECS[i].hit);

    @(negedge clk);
    check(flag_valid == 1'b0, "R7 pulse one cycle", flag_valid, 0);

    // R8 saturating burst, step 4 on a fresh entry
    saw_full = 1'b0;
    obs_n = 0;
    rec_en = 1'b1;
    for (int i = 0; i < NBURST; ) begin
      @(negedge clk);
      acc_valid = 1'b1; acc_pc = 32'h600; acc_addr = 32'h8000 + 32'(4*i);
      if (acc_ready) i++;
      else saw_full = 1'b1;
    end
    @(negedge clk);
    acc_valid = 1'b0;
    repeat (40) @(negedge clk);
    rec_en = 1'b0;
    check(saw_full == 1'b1, "R8 ready dropped when full", saw_full, 1);
    check(obs_n == NBURST, "R8 result count", obs_n, NBURST);
    for (int i = 0; i < NBURST && i < obs_n; i++) begin
      logic eh;
      eh = (i >= 2);
      check(obs_hit[i] == eh, "R8 R4 burst order flag", obs_hit[i], eh);
      if (!eh) check(obs_miss[i] && obs_addr[i] == 32'h8000 + 32'(4*i),
                     "R8 R5 burst miss addr", obs_addr[i], 32'h8000 + 32'(4*i));
    end

    // R1 R3: reset clears entries; continuing step of 0x100 must miss
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_access(32'h100, 32'h5000, 1'b0);
    do_access(32'h100, 32'h5000, 1'b1);
    do_access(32'h100, 32'h5010, 1'b0);
    do_access(32'h100, 32'h5020, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule